// File: doc/BRIEF.md
# Source-Routed Input Port with Packet-Locked Routing

This block is one input port of a switch that moves packets by cut-through or wormhole forwarding. Flits arrive from the link one per cycle and enter a small queue. A routing state machine watches the front of that queue. When a packet's opening flit reaches the front, the machine reads the output index from the low bits of the payload and raises a request line to that output. Once that output grants, it streams the whole packet through. It makes no new decision until the closing flit has left.

The route field is consumed at this hop. Before an opening flit is forwarded, its payload is shifted right by the width of the index, so the next switch finds its own index in the low bits. Each port has its own routing machine and shares none with its neighbours. While the front packet waits for its output, nothing behind it moves. This head-of-line blocking is the intended behaviour.

Top module: `rp_input_port`

## Requirements
- R1: The queue accepts a flit on every cycle that `in_valid` is high and `in_ready` (equal to not `full`) is high. While the port is streaming, a flit can enter and another can leave in the same cycle. After DEPTH accepted flits with none removed, `full` is high and `in_ready` is low. Flits leave in arrival order, and none are lost or overwritten.
- R2: The flit kind is 2 bits: 0 = body, 1 = head, 2 = tail, 3 = single-flit packet. Head and single open a route. Tail and single close it.
- R3: When an opening flit is at the front and the port is idle, `req` becomes one-hot at bit `in_data[RW-1:0]` of that flit from the next cycle on (RW = log2 NUM_OUT).
- R4: `out_valid` is high only when the queue is not empty, the port has moved to streaming, and `gnt` is high for the requested output. The first flit of a packet appears no earlier than the cycle after the grant is seen.
- R5: An opening flit leaves with its payload shifted right by RW bits and zero-filled. Body and tail payloads leave unchanged. The kind is forwarded unchanged.
- R6: `req` stays on the same single output for every flit of the packet. It is low in the cycle after the closing flit is accepted.
- R7: While the front packet waits for its grant, no flit leaves, even if later packets target outputs that are granting. Grants on other outputs have no effect.
- R8: A body or tail flit that reaches the front while the port is idle is discarded. It raises no request and produces no output.
- R9: After reset, `req` is zero, `out_valid` is low, `empty` is high and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Link flit present |
| in_kind | input | 2 | Kind of incoming flit |
| in_data | input | DATA_W | Incoming flit payload |
| in_ready | output | 1 | Queue can accept a flit |
| req | output | NUM_OUT | One-hot request to an output |
| gnt | input | NUM_OUT | Grants from the outputs |
| out_valid | output | 1 | Flit forwarded to crossbar this cycle |
| out_kind | output | 2 | Kind of forwarded flit |
| out_data | output | DATA_W | Forwarded payload, route field stripped on opening flits |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |

## Verification
Every cycle, the assertions check the following:
- `req` is never more than one-hot.
- A forwarded flit always coincides with a grant on the requested output.
- `req` holds steady mid-packet and falls right after a closing flit.
- The queue never reports full and empty at once, and stays full until a flit leaves.

Only the bench's scenarios can show the rest:
- payloads arrive intact and in order across every output index and every packet length;
- the route field is stripped;
- the queue actually blocks behind a waiting head;
- stray body flits vanish without trace.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic [1:0] {
        FK_BODY = 2'd0,
        FK_HEAD = 2'd1,
        FK_TAIL = 2'd2,
        FK_SOLO = 2'd3
    } flit_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } route_state_e;

    localparam int KIND_W = 2;

    function automatic logic kind_opens(input logic [1:0] k);
        return (k == FK_HEAD) || (k == FK_SOLO);
    endfunction

    function automatic logic kind_closes(input logic [1:0] k);
        return (k == FK_TAIL) || (k == FK_SOLO);
    endfunction

endpackage

// File: rtl/rp_flit_fifo.sv
module rp_flit_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp;
    logic [AW:0]      rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                mem[wp[AW-1:0]] <= wdata;
                wp <= wp + 1'b1;
            end
            if (pop && !empty) begin
                rp <= rp + 1'b1;
            end
        end
    end

    // R1: occupancy flags are never both asserted
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R1: a full queue stays full until something is removed
    a_r1_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

endmodule

// File: rtl/rp_route_strip.sv
module rp_route_strip #(
    parameter int DATA_W = 16,
    parameter int RW     = 2
) (
    input  logic [1:0]        kind,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);
    import rp_pkg::*;

    always_comb begin
        if (kind_opens(kind)) data_out = data_in >> RW;
        else                  data_out = data_in;
    end

endmodule

// File: rtl/rp_route_fsm.sv
module rp_route_fsm #(
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               front_valid,
    input  logic [1:0]         front_kind,
    input  logic [DATA_W-1:0]  front_data,
    input  logic [NUM_OUT-1:0] gnt,
    output logic [NUM_OUT-1:0] req,
    output logic               fwd,
    output logic               pop
);
    import rp_pkg::*;

    localparam int RW = $clog2(NUM_OUT);

    route_state_e state;
    route_state_e state_nx;
    logic [RW-1:0] sel;
    logic          granted;
    logic          discard;

    assign granted = gnt[sel];
    assign fwd     = (state == ST_XFER) && front_valid && granted;
    assign discard = (state == ST_IDLE) && front_valid && !kind_opens(front_kind);
    assign pop     = fwd || discard;

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_req
            assign req[g] = (state != ST_IDLE) && (sel == RW'(g));
        end
    endgenerate

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (front_valid && kind_opens(front_kind)) state_nx = ST_REQ;
            ST_REQ:  if (granted) state_nx = ST_XFER;
            ST_XFER: if (fwd && kind_closes(front_kind)) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sel   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && front_valid && kind_opens(front_kind))
                sel <= front_data[RW-1:0];
        end
    end

    // R6: at most one output requested at a time
    a_r6_req_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req));

    // R6: request holds for the whole packet
    a_r6_req_steady: assert property (@(posedge clk) disable iff (rst)
        ((req != '0) && !(fwd && kind_closes(front_kind))) |=> $stable(req));

    // R6: request released the cycle after the closing flit
    a_r6_release_after_tail: assert property (@(posedge clk) disable iff (rst)
        (fwd && kind_closes(front_kind)) |=> (req == '0));

    // R8: a stray flit never raises a request
    a_r8_stray_no_req: assert property (@(posedge clk) disable iff (rst)
        discard |=> (req == '0));

endmodule

// File: rtl/rp_input_port.sv
module rp_input_port #(
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_kind,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic [NUM_OUT-1:0] req,
    input  logic [NUM_OUT-1:0] gnt,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic [DATA_W-1:0]  out_data,
    output logic               full,
    output logic               empty
);
    import rp_pkg::*;

    localparam int RW     = $clog2(NUM_OUT);
    localparam int ENTRY_W = KIND_W + DATA_W;

    logic [ENTRY_W-1:0] front;
    logic [1:0]         front_kind;
    logic [DATA_W-1:0]  front_data;
    logic               pop;
    logic               fwd;

    rp_flit_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid),
        .wdata ({in_kind, in_data}),
        .pop   (pop),
        .rdata (front),
        .full  (full),
        .empty (empty)
    );

    assign front_kind = front[ENTRY_W-1 -: KIND_W];
    assign front_data = front[DATA_W-1:0];
    assign in_ready   = !full;

    rp_route_fsm #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .front_valid (!empty),
        .front_kind  (front_kind),
        .front_data  (front_data),
        .gnt         (gnt),
        .req         (req),
        .fwd         (fwd),
        .pop         (pop)
    );

    rp_route_strip #(.DATA_W(DATA_W), .RW(RW)) u_strip (
        .kind     (front_kind),
        .data_in  (front_data),
        .data_out (out_data)
    );

    assign out_valid = fwd;
    assign out_kind  = front_kind;

    // R4: a forwarded flit always has a grant on the requested output
    a_r4_valid_needs_grant: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((req & gnt) != '0));

    // R4: nothing is forwarded from an empty queue
    a_r4_valid_needs_data: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !empty);

endmodule

// File: tb/rp_input_port_bench.sv
module rp_input_port_bench;
    localparam int NO = 4;
    localparam int DW = 16;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_kind = 2'd0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic [NO-1:0] req;
    logic [NO-1:0] gnt_mask = '0;
    logic [NO-1:0] gnt;
    logic          out_valid;
    logic [1:0]    out_kind;
    logic [DW-1:0] out_data;
    logic          full;
    logic          empty;

    int checks = 0;
    int fails  = 0;
    int stalls = 0;
    int beats  = 0;

    logic [1:0]    exp_kind [512];
    logic [DW-1:0] exp_data [512];
    logic [NO-1:0] exp_req  [512];
    int wr_i = 0;
    int rd_i = 0;
    logic after_close = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    assign gnt = req & gnt_mask;

    rp_input_port #(.NUM_OUT(NO), .DATA_W(DW), .DEPTH(DP)) u_rp_input_port (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_data(in_data), .in_ready(in_ready), .req(req), .gnt(gnt),
        .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data),
        .full(full), .empty(empty)
    );

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (after_close) begin
                check("R6 req low after closing flit", req == '0, req, 0);
                after_close <= 1'b0;
            end
            if (out_valid) begin
                beats++;
                if (rd_i >= wr_i) begin
                    check("R8/R7 unexpected output flit", 1'b0, out_data, 0);
                end else begin
                    check("R2 kind", out_kind == exp_kind[rd_i], out_kind, exp_kind[rd_i]);
                    check("R5 payload", out_data == exp_data[rd_i], out_data, exp_data[rd_i]);
                    check("R3 req index", req == exp_req[rd_i], req, exp_req[rd_i]);
                    if (out_kind == 2'd2 || out_kind == 2'd3) after_close <= 1'b1;
                    rd_i++;
                end
            end
        end
    end

    task automatic push_flit(input logic [1:0] k, input logic [DW-1:0] d,
                             input int port, input bit expect_out);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = k;
        in_data  = d;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
        end
        if (expect_out) begin
            exp_kind[wr_i] = k;
            exp_data[wr_i] = (k == 2'd1 || k == 2'd3) ? (d >> 2) : d;
            exp_req[wr_i]  = NO'(1) << port;
            wr_i++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_packet(input int port, input int len, input int id);
        for (int i = 0; i < len; i++) begin
            logic [1:0] k;
            logic [DW-1:0] d;
            if (len == 1)          k = 2'd3;
            else if (i == 0)       k = 2'd1;
            else if (i == len - 1) k = 2'd2;
            else                   k = 2'd0;
            if (i == 0) d = DW'((id * 37 + 5) << 2) | DW'(port);
            else        d = DW'(id * 256 + i * 17 + 1);
            push_flit(k, d, port, 1'b1);
        end
    endtask

    task automatic drain;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (rd_i == wr_i && empty && req == '0) break;
        end
        check("R1 all flits delivered", rd_i == wr_i, rd_i, wr_i);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 req after reset", req == '0, req, 0);
        check("R9 out_valid after reset", out_valid == 1'b0, out_valid, 0);
        check("R9 empty after reset", empty == 1'b1, empty, 1);
        check("R9 in_ready after reset", in_ready == 1'b1, in_ready, 1);
        rst = 1'b0;

        // sweep every output index and packet length with open grants
        gnt_mask = '1;
        for (int p = 0; p < NO; p++) begin
            for (int l = 1; l <= 5; l++) begin
                send_packet(p, l, p * 8 + l);
            end
        end
        drain();

        // R1: back-to-back streaming of a long packet, no stalls
        stalls = 0;
        send_packet(2, 12, 99);
        drain();
        check("R1 no stalls while streaming", stalls == 0, stalls, 0);

        // R1 fill: no grants, queue fills
        gnt_mask = '0;
        send_packet(1, DP, 120);
        @(negedge clk);
        check("R1 full after DEPTH flits", full == 1'b1, full, 1);
        check("R1 in_ready low when full", in_ready == 1'b0, in_ready, 0);
        check("R3 req points to port 1", req == 4'b0010, req, 4'b0010);
        repeat (3) @(negedge clk);
        check("R4 no output without grant", out_valid == 1'b0, out_valid, 0);
        gnt_mask = '1;
        drain();

        // R7 head-of-line blocking: A to port 1 waits, B to port 2 granted
        gnt_mask = 4'b0100;
        send_packet(1, 2, 130);
        send_packet(2, 1, 131);
        beats = 0;
        repeat (8) @(negedge clk);
        check("R7 nothing leaves while head blocked", beats == 0, beats, 0);
        check("R7 req stays on blocked output", req == 4'b0010, req, 4'b0010);
        gnt_mask = '1;
        drain();

        // R8 stray body and tail flits discarded
        beats = 0;
        push_flit(2'd0, 16'h1234, 0, 1'b0);
        push_flit(2'd2, 16'h0ff1, 0, 1'b0);
        repeat (4) @(negedge clk);
        check("R8 stray flits produce no output", beats == 0, beats, 0);
        check("R8 stray flits raise no request", req == '0, req, 0);
        check("R8 queue empty after discard", empty == 1'b1, empty, 1);

        // packet after strays still routes
        send_packet(3, 3, 140);
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule